// File: doc/BRIEF.md
# Character LCD Parallel Bus Engine

This block performs one register transfer at a time to a character LCD module over the module's parallel bus. A host asserts a request with a register-select flag, a read flag, a byte and a bus-width choice. The engine then drives the select, direction and enable lines and the data lines. In narrow mode it splits the byte into two nibbles, sending the upper nibble first. When the transfer ends it gives a one-cycle completion pulse, and for a read it also returns the assembled byte.

Every interval is derived at elaboration from the clock frequency in MHz and the nanosecond minimums of the bus. These minimums are the control setup time, the enable high width, the write data setup, the read data delay, the hold time and the enable cycle time. A controlling wrapper can issue repeated instruction reads to poll the module's busy flag. It can also issue plain writes for commands and characters.

Top module: `lcd_bus_engine`

## Requirements
- R1: After synchronous reset, `lcd_e`=0, `lcd_db_oe`=0, `busy`=0, `done`=0, `rd_data`=0x00, `lcd_rw`=1 and `lcd_rs`=0.
- R2: `lcd_rs` equals the accepted `req_rs` (0 = instruction register, 1 = data register). `lcd_rw` is 1 for a read and 0 for a write. Both, and `lcd_db_out`, stay constant while `lcd_e` is high.
- R3: In wide mode (`req_wide`=1) a write produces exactly one enable pulse. `lcd_e` rises AS cycles after the accepting edge and stays high for PW cycles. The whole byte is on `lcd_db_out` with `lcd_db_oe`=1 throughout.
- R4: In narrow mode (`req_wide`=0) a write produces two enable pulses. The first carries byte bits 7..4 on `lcd_db_out[7:4]`, and the second carries bits 3..0 on `lcd_db_out[7:4]`. `lcd_db_out[3:0]` is 0 in both.
- R5: Each enable pulse occupies AS+PW+LO cycles, so the rise-to-rise interval between the two nibbles is at least the enable cycle time.
- R6: During a read, `lcd_db_oe` stays 0. The data lines are sampled on the last cycle `lcd_e` is high, and a wide read returns all eight sampled bits on `rd_data`.
- R7: A narrow read takes `lcd_db_in[7:4]` from the first pulse into `rd_data[7:4]` and from the second pulse into `rd_data[3:0]`, ignoring `lcd_db_in[3:0]`.
- R8: `done` is a one-cycle pulse asserted AS+PW+LO cycles after the last enable rise began its setup, and `busy` falls on the same edge. `rd_data` is valid when `done` is high and is left unchanged by writes.
- R9: `busy` is high from the cycle after acceptance until `done`. A request presented while `busy` is high is ignored.
- R10: Each delay is ceil(ns × MHz / 1000) cycles, with a minimum of 1. PW is the largest of the pulse width, the write data setup and the read data delay plus one cycle. LO is the larger of the hold time and the cycle time minus AS and PW. At 50 MHz this gives AS=7, PW=23 and LO=20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_rs | input | 1 | 1 = data register, 0 = instruction register |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_wide | input | 1 | 1 = eight data lines, 0 = four |
| req_data | input | 8 | Byte to write |
| lcd_rs | output | 1 | Register select line |
| lcd_rw | output | 1 | Direction line, 1 = module drives |
| lcd_e | output | 1 | Enable strobe |
| lcd_db_out | output | 8 | Data lines driven by the host |
| lcd_db_oe | output | 1 | Output enable for the data drivers |
| lcd_db_in | input | 8 | Data lines as seen from the module |
| rd_data | output | 8 | Byte returned by the last read |
| done | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | Transfer in progress |

## Verification
Several properties are checked on every cycle:
- Select, direction and data lines do not move while the enable is high.
- The data drivers stay off whenever the direction line reads.
- Each enable pulse lasts exactly PW cycles.
- The enable is high only while busy.
- Completion is a single pulse that ends busy.

The bench scenarios are needed for what these properties cannot show: the exact rise and completion cycles, nibble order and the zeroed low lines, assembly of a narrow read from two samples, retention of the read byte across writes, and rejection of a request made in mid-transfer.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic       rs;
        logic       rd;
        logic       wide;
        logic [7:0] byte_v;
    } xfer_t;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
    import lcd_bus_pkg::*;
#(
    parameter int AS_CYC = 7,
    parameter int PW_CYC = 23,
    parameter int LO_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic wide,
    output logic accept,
    output logic e,
    output logic busy,
    output logic done,
    output logic sample,
    output logic second
);
    localparam int CNT_MAX = imax(imax(AS_CYC, PW_CYC), LO_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    phase_e           st;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);
    assign busy     = (st != PH_IDLE);
    assign accept   = start && (st == PH_IDLE);
    assign sample   = (st == PH_HIGH) && cnt_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= PH_IDLE;
            cnt    <= '0;
            e      <= 1'b0;
            done   <= 1'b0;
            second <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                PH_IDLE: begin
                    if (start) begin
                        st     <= PH_SETUP;
                        cnt    <= CNT_W'(AS_CYC - 1);
                        second <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        st  <= PH_HIGH;
                        cnt <= CNT_W'(PW_CYC - 1);
                        e   <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt_zero) begin
                        st  <= PH_HOLD;
                        cnt <= CNT_W'(LO_CYC - 1);
                        e   <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else if (!wide && !second) begin
                        st     <= PH_SETUP;
                        cnt    <= CNT_W'(AS_CYC - 1);
                        second <= 1'b1;
                    end else begin
                        st   <= PH_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    // Independent run-length counter of the enable pulse.
    logic [CNT_W:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst)    hi_run <= '0;
        else if (e) hi_run <= hi_run + 1'b1;
        else        hi_run <= '0;
    end

    p_pulse_width_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(e) |-> (hi_run == (CNT_W+1)'(PW_CYC)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_e_within_busy_r9: assert property (@(posedge clk) disable iff (rst)
        e |-> busy);

endmodule

// File: rtl/lcd_lane_path.sv
module lcd_lane_path
    import lcd_bus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  xfer_t      req,
    input  logic       busy,
    input  logic       second,
    input  logic       sample,
    input  logic [7:0] db_in,
    output logic       rs,
    output logic       rw,
    output logic       wide,
    output logic [7:0] db_out,
    output logic       db_oe,
    output logic [7:0] rd_data
);
    xfer_t      cur;
    logic [3:0] nib;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{rs: 1'b0, rd: 1'b1, wide: 1'b1, byte_v: 8'h00};
        end else if (accept) begin
            cur <= req;
        end
    end

    assign rs    = cur.rs;
    assign rw    = cur.rd;
    assign wide  = cur.wide;
    assign db_oe = busy && !cur.rd;
    assign nib   = second ? cur.byte_v[3:0] : cur.byte_v[7:4];
    assign db_out = cur.wide ? cur.byte_v : {nib, 4'b0000};

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= 8'h00;
        end else if (sample && cur.rd) begin
            if (cur.wide)    rd_data        <= db_in;
            else if (second) rd_data[3:0]   <= db_in[7:4];
            else             rd_data[7:4]   <= db_in[7:4];
        end
    end

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
    import lcd_bus_pkg::*;
#(
    parameter int CLK_MHZ   = 50,
    parameter int T_AS_NS   = 140,
    parameter int T_PW_NS   = 450,
    parameter int T_CYC_NS  = 1000,
    parameter int T_DSW_NS  = 195,
    parameter int T_DDR_NS  = 320,
    parameter int T_HOLD_NS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_rs,
    input  logic       req_rd,
    input  logic       req_wide,
    input  logic [7:0] req_data,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] lcd_db_out,
    output logic       lcd_db_oe,
    input  logic [7:0] lcd_db_in,
    output logic [7:0] rd_data,
    output logic       done,
    output logic       busy
);
    localparam int AS_CYC = ns_to_cyc(T_AS_NS, CLK_MHZ);
    localparam int PW_CYC = imax(imax(ns_to_cyc(T_PW_NS, CLK_MHZ),
                                      ns_to_cyc(T_DSW_NS, CLK_MHZ)),
                                 ns_to_cyc(T_DDR_NS, CLK_MHZ) + 1);
    localparam int LO_CYC = imax(ns_to_cyc(T_HOLD_NS, CLK_MHZ),
                                 ns_to_cyc(T_CYC_NS, CLK_MHZ) - AS_CYC - PW_CYC);

    logic  accept, sample, second, cur_wide;
    xfer_t req;

    assign req = '{rs: req_rs, rd: req_rd, wide: req_wide, byte_v: req_data};

    lcd_phase_seq #(
        .AS_CYC(AS_CYC),
        .PW_CYC(PW_CYC),
        .LO_CYC(LO_CYC)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (req_valid),
        .wide  (cur_wide),
        .accept(accept),
        .e     (lcd_e),
        .busy  (busy),
        .done  (done),
        .sample(sample),
        .second(second)
    );

    lcd_lane_path u_lane (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .req    (req),
        .busy   (busy),
        .second (second),
        .sample (sample),
        .db_in  (lcd_db_in),
        .rs     (lcd_rs),
        .rw     (lcd_rw),
        .wide   (cur_wide),
        .db_out (lcd_db_out),
        .db_oe  (lcd_db_oe),
        .rd_data(rd_data)
    );

    p_read_no_drive_r6: assert property (@(posedge clk) disable iff (rst)
        lcd_rw |-> !lcd_db_oe);

    p_stable_in_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (lcd_e && $past(lcd_e)) |->
            ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_out)));

endmodule

// File: tb/lcd_bus_engine_test.sv
module lcd_bus_engine_test;
    localparam int CLK_PERIOD = 20;
    localparam int MHZ = 1000 / CLK_PERIOD;

    function automatic int cyc_of(input int ns);
        int c;
        c = (ns * MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    int AS, PW, LO, SLOT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_rs = 1'b0, req_rd = 1'b0, req_wide = 1'b1;
    logic [7:0] req_data = 8'h00;
    logic lcd_rs, lcd_rw, lcd_e, lcd_db_oe, done, busy;
    logic [7:0] lcd_db_out, lcd_db_in, rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_bus_engine uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_rs(req_rs),
        .req_rd(req_rd), .req_wide(req_wide), .req_data(req_data),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
        .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in),
        .rd_data(rd_data), .done(done), .busy(busy)
    );

    int errors = 0, checks = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Pulse monitor, sampled at the falling clock edge.
    int         npulse;
    int         rise_t [4];
    int         fall_t [4];
    logic [7:0] out_at [4];
    logic       oe_at  [4];
    logic       rs_at  [4];
    logic       rw_at  [4];
    logic       e_prev = 1'b0;
    logic       oe_read = 1'b0;
    logic [7:0] mod_first = 8'h00, mod_second = 8'h00;

    assign lcd_db_in = (npulse == 0) ? mod_first : mod_second;

    always @(negedge clk) begin
        if (lcd_e && !e_prev && npulse < 4) begin
            rise_t[npulse] = cyc;
            out_at[npulse] = lcd_db_out;
            oe_at[npulse]  = lcd_db_oe;
            rs_at[npulse]  = lcd_rs;
            rw_at[npulse]  = lcd_rw;
        end
        if (!lcd_e && e_prev) begin
            if (npulse < 4) fall_t[npulse] = cyc;
            npulse = npulse + 1;
        end
        if (lcd_rw && lcd_db_oe) oe_read = 1'b1;
        e_prev = lcd_e;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    int acc_t, done_t;

    task automatic run_xfer(input logic rs, input logic rd, input logic [7:0] d,
                            input logic wide);
        npulse  = 0;
        oe_read = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_rs = rs; req_rd = rd; req_data = d; req_wide = wide;
        @(negedge clk);
        req_valid = 1'b0;
        acc_t = cyc;
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
        done_t = -1;
        for (int i = 0; i < 400 && done_t < 0; i++) begin
            if (done) done_t = cyc;
            else @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(lcd_e == 0 && lcd_db_oe == 0 && busy == 0 && done == 0, "R1 idle outputs",
            {lcd_e, lcd_db_oe, busy, done}, 0);
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        chk(lcd_rw == 1 && lcd_rs == 0, "R1 rw/rs", {lcd_rw, lcd_rs}, 2);
    endtask

    task automatic t_write_wide();
        run_xfer(1'b1, 1'b0, 8'hA5, 1'b1);
        chk(npulse == 1, "R3 one pulse", npulse, 1);
        chk(rise_t[0] - acc_t == AS, "R3 R10 setup cycles", rise_t[0] - acc_t, AS);
        chk(fall_t[0] - rise_t[0] == PW, "R3 R10 pulse cycles", fall_t[0] - rise_t[0], PW);
        chk(out_at[0] == 8'hA5 && oe_at[0], "R3 data driven", out_at[0], 8'hA5);
        chk(rs_at[0] == 1 && rw_at[0] == 0, "R2 data write lines",
            {rs_at[0], rw_at[0]}, 2);
        chk(done_t - acc_t == SLOT, "R8 done cycle", done_t - acc_t, SLOT);
        chk(busy == 0, "R8 busy falls with done", busy, 0);
        @(negedge clk);
        chk(done == 0, "R8 single pulse", done, 0);
    endtask

    task automatic t_write_narrow();
        run_xfer(1'b0, 1'b0, 8'h3C, 1'b0);
        chk(npulse == 2, "R4 two pulses", npulse, 2);
        chk(out_at[0] == 8'h30, "R4 high nibble first", out_at[0], 8'h30);
        chk(out_at[1] == 8'hC0, "R4 low nibble second", out_at[1], 8'hC0);
        chk(rs_at[0] == 0 && rs_at[1] == 0, "R2 instruction select",
            {rs_at[0], rs_at[1]}, 0);
        chk(rise_t[1] - rise_t[0] == SLOT, "R5 R10 rise to rise",
            rise_t[1] - rise_t[0], SLOT);
        chk(rise_t[1] - rise_t[0] >= cyc_of(1000), "R5 cycle minimum",
            rise_t[1] - rise_t[0], cyc_of(1000));
        chk(done_t - acc_t == 2 * SLOT, "R8 narrow done cycle", done_t - acc_t, 2 * SLOT);
    endtask

    task automatic t_read_wide();
        mod_first = 8'h8B; mod_second = 8'h00;
        run_xfer(1'b0, 1'b1, 8'hFF, 1'b1);
        chk(!oe_read && !oe_at[0], "R6 no drive on read", oe_read, 0);
        chk(rw_at[0] == 1, "R2 read direction", rw_at[0], 1);
        chk(rd_data == 8'h8B, "R6 wide read byte", rd_data, 8'h8B);
    endtask

    task automatic t_read_narrow();
        mod_first = 8'hD9; mod_second = 8'h6A;
        run_xfer(1'b1, 1'b1, 8'h00, 1'b0);
        chk(npulse == 2 && !oe_read, "R6 narrow read pulses undriven", npulse, 2);
        chk(rd_data == 8'hD6, "R7 nibble assembly", rd_data, 8'hD6);
    endtask

    task automatic t_write_keeps_rd();
        mod_first = 8'h11; mod_second = 8'h22;
        run_xfer(1'b1, 1'b0, 8'h5A, 1'b1);
        chk(rd_data == 8'hD6, "R8 write leaves rd_data", rd_data, 8'hD6);
    endtask

    task automatic t_busy_ignore();
        npulse = 0;
        @(negedge clk);
        req_valid = 1'b1; req_rs = 1'b1; req_rd = 1'b0; req_data = 8'h11; req_wide = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        acc_t = cyc;
        repeat (10) @(negedge clk);
        req_valid = 1'b1; req_data = 8'hFF; req_rd = 1'b1; req_wide = 1'b0;
        repeat (AS + PW) @(negedge clk);
        req_valid = 1'b0;
        done_t = -1;
        for (int i = 0; i < 400 && done_t < 0; i++) begin
            if (done) done_t = cyc;
            else @(negedge clk);
        end
        chk(out_at[0] == 8'h11 && rw_at[0] == 0, "R9 first request kept",
            out_at[0], 8'h11);
        chk(done_t - acc_t == SLOT, "R9 timing unaffected", done_t - acc_t, SLOT);
        repeat (3 * SLOT) @(negedge clk);
        chk(npulse == 1 && busy == 0, "R9 late request ignored", npulse, 1);
    endtask

    bit finished = 1'b0;

    initial begin
        AS   = cyc_of(140);
        PW   = cyc_of(450);
        if (cyc_of(195) > PW) PW = cyc_of(195);
        if (cyc_of(320) + 1 > PW) PW = cyc_of(320) + 1;
        LO   = cyc_of(1000) - AS - PW;
        if (LO < cyc_of(10)) LO = cyc_of(10);
        SLOT = AS + PW + LO;
        npulse = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_wide();
        t_write_narrow();
        t_read_wide();
        t_read_narrow();
        t_write_keeps_rd();
        t_busy_ignore();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule